// File: doc/BRIEF.md
# Successive-Approximation ADC Register Front End

This block is the bus-facing register and sequencing logic of an eight-input, 10-bit successive-approximation converter. An 8-bit CPU reaches it through a small synchronous port. A control byte selects the input, the interrupt mode and one-shot or repeating operation. The result is read back as a high byte and a low byte. A completion indication is given either as a status flag that software polls or as an interrupt request line.

Writing the control byte aborts whatever conversion is running. If the written input code is one of the eight real inputs, a new conversion starts on that input. Any other code leaves the converter idle. A cycle-counting stub inside the block stands in for the analog converter. The stub finishes a fixed number of clock cycles after it starts and returns the value on `sampleIn`, so that a bench can choose the results.

Register addresses on `busAddr`: 0 is the control byte, 1 is the result high byte, 2 is the result low byte, and 3 reads as zero. Read data is combinational from the addressed register. A read has its side effects at the clock edge while `busRd` is high.

Top module: `adc_regif`

## Requirements
- R1: After reset, the control byte reads 0x1F, both result bytes read 0x00, `irqReq` is low and no conversion runs.
- R2: A control write whose bits 4..0 hold a code from 0 to 7 starts a conversion. Its result is taken at the 17th rising edge after the write edge, and not at the 16th.
- R3: While the interrupt enable (control bit 6) is 0, control bit 7 becomes 1 when a conversion ends. It stays 1 until either result byte is read, and `irqReq` stays low.
- R4: While the interrupt enable is 1, control bit 7 reads 0 and `irqReq` rises when a conversion ends. Writing the enable to 1 discards a pending flag.
- R5: `irqReq` falls after a read of either result byte or after any control write.
- R6: Bit 7 of a control write is ignored and does not clear the flag. Bits 6..0 read back as written.
- R7: The high byte (address 1) reads the result's bits 9..8 in its bits 1..0, with bits 7..2 zero. The low byte (address 2) reads the result's bits 7..0.
- R8: A high-byte read freezes the low byte at its value from that moment, through later conversions, until the low byte is read.
- R9: With control bit 5 set, a new conversion on the same input starts each time one ends, every 17 cycles. With the bit clear, one conversion runs per write.
- R10: A control write during a conversion discards it. The next result comes 17 edges after that write.
- R11: A written code from 8 to 31 (0x1F powers the converter off) starts nothing and stops a running conversion.
- R12: When a conversion ends at the same edge as a result read, the new completion wins: the flag or the request ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register select |
| busWrData | input | 8 | Write data |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe; its side effects occur at the clock edge |
| busRdData | output | 8 | Read data of the addressed register |
| irqReq | output | 1 | Interrupt request, level |
| sampleIn | input | 10 | Value the converter stub returns at completion |

## Verification
The hardest case to reach is a result read landing on the very edge where a conversion completes. At that edge the clearing read and the setting completion collide, and the high-byte read also takes its frozen copy of the low byte. The bench starts a one-shot conversion with a control write. It then counts sixteen edges and places a high-byte read on the seventeenth. It checks that the flag remains set, that the read returned the older high byte, and that the following low-byte read returns the matching older low byte. The same edge counting drives the abort case, where a second write arrives mid-conversion and the completion time is measured from that second write.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int CH_W = 5;
  localparam int DEF_NUM_CH = 8;
  localparam int DEF_RES_W = 10;
  localparam int DEF_CONV_CYCLES = 17;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd2;

  typedef struct packed {
    logic ctrlWr;
    logic hiRd;
    logic loRd;
    logic doneTake;
  } strobe_t;

  typedef struct packed {
    logic intEn;
    logic contEn;
    logic [CH_W-1:0] chan;
  } ctrl_t;
endpackage

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
  parameter int RES_W = 10,
  parameter int CONV_CYCLES = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convStart,
  input  logic             convStop,
  input  logic [RES_W-1:0] sampleIn,
  output logic             convDone,
  output logic [RES_W-1:0] convResult
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic busy;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (convStart) begin
      busy <= 1'b1;
      cnt  <= CNT_LOAD;
    end else if (convStop) begin
      busy <= 1'b0;
    end else if (busy && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign convDone   = busy && (cnt == '0);
  assign convResult = sampleIn;
endmodule

// File: rtl/adc_regif_ctrl.sv
module adc_regif_ctrl
  import adc_regif_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [CH_W-1:0]   wrChan,
  input  logic              contNow,
  input  logic              convDone,
  output strobe_t           stb,
  output logic              convStart,
  output logic              convStop
);
  logic wrChanOk;

  always_comb begin
    stb.ctrlWr   = busWr && (busAddr == ADDR_CTRL);
    stb.hiRd     = busRd && (busAddr == ADDR_HI);
    stb.loRd     = busRd && (busAddr == ADDR_LO);
    // a control write aborts the conversion, so a simultaneous completion is dropped
    stb.doneTake = convDone && !stb.ctrlWr;
    wrChanOk     = wrChan < CH_W'(NUM_CH);
    convStart    = (stb.ctrlWr && wrChanOk) || (stb.doneTake && contNow);
    convStop     = (stb.ctrlWr && !wrChanOk) || (stb.doneTake && !contNow);
  end
endmodule

// File: rtl/adc_regif_dp.sv
module adc_regif_dp
  import adc_regif_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-2:0] wrFields,
  input  logic [RES_W-1:0]  convResult,
  output ctrl_t             ctrlNow,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqReq
);
  localparam int WIDE_W = 2 * DATA_W;

  ctrl_t ctrlReg;
  logic flagReg, irqReg, loFrozen;
  logic [DATA_W-1:0] resHi, resLo, loHold;
  logic [WIDE_W-1:0] resWide;

  assign resWide = WIDE_W'(convResult);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '{intEn: 1'b0, contEn: 1'b0, chan: '1};
      flagReg  <= 1'b0;
      irqReg   <= 1'b0;
      resHi    <= '0;
      resLo    <= '0;
      loHold   <= '0;
      loFrozen <= 1'b0;
    end else begin
      if (stb.ctrlWr) ctrlReg <= ctrl_t'(wrFields);

      if (stb.doneTake && !ctrlReg.intEn) flagReg <= 1'b1;
      else if (stb.hiRd || stb.loRd) flagReg <= 1'b0;
      else if (stb.ctrlWr && wrFields[DATA_W-2]) flagReg <= 1'b0;

      if (stb.doneTake && ctrlReg.intEn) irqReg <= 1'b1;
      else if (stb.hiRd || stb.loRd || stb.ctrlWr) irqReg <= 1'b0;

      if (stb.doneTake) begin
        resHi <= resWide[WIDE_W-1:DATA_W];
        resLo <= resWide[DATA_W-1:0];
      end

      if (stb.hiRd) begin
        loHold   <= resLo;
        loFrozen <= 1'b1;
      end else if (stb.loRd) begin
        loFrozen <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_CTRL: busRdData = {flagReg & ~ctrlReg.intEn, ctrlReg};
      ADDR_HI:   busRdData = resHi;
      ADDR_LO:   busRdData = loFrozen ? loHold : resLo;
      default:   busRdData = '0;
    endcase
  end

  assign ctrlNow = ctrlReg;
  assign irqReq  = irqReg;
endmodule

// File: rtl/adc_regif.sv
module adc_regif
  import adc_regif_pkg::*;
#(
  parameter int NUM_CH = DEF_NUM_CH,
  parameter int RES_W = DEF_RES_W,
  parameter int CONV_CYCLES = DEF_CONV_CYCLES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqReq,
  input  logic [RES_W-1:0]  sampleIn
);
  strobe_t stb;
  ctrl_t ctrlNow;
  logic convStart, convStop, convDone;
  logic [RES_W-1:0] convResult;
  logic unusedWrTop;

  assign unusedWrTop = busWrData[DATA_W-1];

  adc_regif_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .wrChan(busWrData[CH_W-1:0]), .contNow(ctrlNow.contEn),
    .convDone(convDone), .stb(stb),
    .convStart(convStart), .convStop(convStop)
  );

  adc_regif_dp #(.RES_W(RES_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr),
    .wrFields(busWrData[DATA_W-2:0]), .convResult(convResult),
    .ctrlNow(ctrlNow), .busRdData(busRdData), .irqReq(irqReq)
  );

  adc_conv_stub #(.RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk(clk), .rstN(rstN), .convStart(convStart), .convStop(convStop),
    .sampleIn(sampleIn), .convDone(convDone), .convResult(convResult)
  );
endmodule

// File: rtl/adc_regif_chk.sv
module adc_regif_chk
  import adc_regif_pkg::*;
#(
  parameter int RES_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              busWr,
  input logic              busRd,
  input logic [DATA_W-1:0] busRdData,
  input logic              irqReq,
  input logic              convDone
);
  logic intEnShadow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intEnShadow <= 1'b0;
    else if (busWr && busAddr == ADDR_CTRL) intEnShadow <= busWrData[6];
  end

  // R4: the flag reads zero while interrupts are enabled
  p_flag_masked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (intEnShadow && busAddr == ADDR_CTRL) |-> !busRdData[7]);

  // R3: no request while in polled mode
  p_no_irq_polled_r3: assert property (@(posedge clk) disable iff (!rstN)
    !intEnShadow |-> !irqReq);

  // R4: a request only rises after a completion
  p_irq_from_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(convDone));

  // R5: a control write drops the request
  p_irq_wr_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_CTRL) |=> !irqReq);

  // R5: a result read without a completion drops the request
  p_irq_rd_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && (busAddr == ADDR_HI || busAddr == ADDR_LO) && !convDone) |=> !irqReq);

  // R7: upper bits of the high byte are zero
  p_hi_upper_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_HI) |-> ((busRdData >> (RES_W - DATA_W)) == '0));
endmodule

bind adc_regif adc_regif_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
  .busWr(busWr), .busRd(busRd), .busRdData(busRdData),
  .irqReq(irqReq), .convDone(convDone)
);

// File: tb/tb_adc_regif.sv
`timescale 1ns/1ps
module tb_adc_regif;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busRdData;
  logic irqReq;
  logic [9:0] sampleIn = '0;

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  logic [7:0] v;

  always #5 clk = ~clk;

  adc_regif dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData),
    .irqReq(irqReq), .sampleIn(sampleIn)
  );

  // {control byte, sample}
  localparam logic [17:0] VEC [0:3] = '{
    {8'h00, 10'h3FF}, {8'h07, 10'h000}, {8'h03, 10'h2A5}, {8'h05, 10'h15A}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [7:0] d);
    busAddr = 2'd0; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    busRd = 1'b0; busAddr = a;
    #1 d = busRdData;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    // R1 reset state
    peek(2'd0, v); chk("R1 ctrl", v, 8'h1F);
    peek(2'd1, v); chk("R1 hi", v, 8'h00);
    peek(2'd2, v); chk("R1 lo", v, 8'h00);
    chk("R1 irq", {7'd0, irqReq}, 8'h00);
    waitCyc(40);
    peek(2'd0, v); chk("R1 idle", v, 8'h1F);

    // table: R2 timing, R3 flag, R7 byte layout
    for (int i = 0; i < 4; i++) begin
      logic [7:0] c;
      logic [9:0] s;
      c = VEC[i][17:10];
      s = VEC[i][9:0];
      sampleIn = s;
      wrCtrl(c);
      waitCyc(16);
      peek(2'd0, v); chk("R2 not yet", v, c);
      waitCyc(1);
      peek(2'd0, v); chk("R2 R3 flag set", v, c | 8'h80);
      chk("R3 no irq", {7'd0, irqReq}, 8'h00);
      rdReg(2'd1, v); chk("R7 hi", v, {6'd0, s[9:8]});
      peek(2'd0, v); chk("R3 flag cleared", v, c);
      rdReg(2'd2, v); chk("R7 lo", v, s[7:0]);
    end

    // R6 and R11: bit 7 ignored, off code starts nothing
    wrCtrl(8'hFF);
    peek(2'd0, v); chk("R6 readback", v, 8'h7F);
    waitCyc(40);
    chk("R11 off no irq", {7'd0, irqReq}, 8'h00);
    wrCtrl(8'h00);
    waitCyc(17);
    wrCtrl(8'h05);
    peek(2'd0, v); chk("R6 write 0 keeps flag", v, 8'h85);
    rdReg(2'd2, v);
    waitCyc(17);
    rdReg(2'd2, v);

    // R12: completion and high read on the same edge (last hi was 0x01, lo 0x5A)
    sampleIn = 10'h2C3;
    wrCtrl(8'h04);
    waitCyc(16);
    rdReg(2'd1, v); chk("R12 old hi", v, 8'h01);
    peek(2'd0, v); chk("R12 flag wins", v, 8'h84);
    rdReg(2'd2, v); chk("R12 R8 paired lo", v, 8'h5A);
    peek(2'd2, v); chk("R8 unfrozen lo", v, 8'hC3);
    peek(2'd1, v); chk("R7 new hi", v, 8'h02);

    // R8: freeze across a later conversion
    sampleIn = 10'h3E7;
    wrCtrl(8'h01);
    waitCyc(17);
    rdReg(2'd1, v); chk("R8 hi", v, 8'h03);
    sampleIn = 10'h0AB;
    wrCtrl(8'h01);
    waitCyc(17);
    peek(2'd1, v); chk("R8 hi moves", v, 8'h00);
    peek(2'd2, v); chk("R8 lo frozen", v, 8'hE7);
    rdReg(2'd2, v); chk("R8 lo read frozen", v, 8'hE7);
    peek(2'd2, v); chk("R8 lo released", v, 8'hAB);

    // R10: abort and restart
    wrCtrl(8'h02);
    waitCyc(10);
    wrCtrl(8'h03);
    waitCyc(16);
    peek(2'd0, v); chk("R10 not yet", v, 8'h03);
    waitCyc(1);
    peek(2'd0, v); chk("R10 done", v, 8'h83);
    rdReg(2'd2, v);

    // R11: stop a running conversion
    wrCtrl(8'h06);
    waitCyc(8);
    wrCtrl(8'h1F);
    waitCyc(30);
    peek(2'd0, v); chk("R11 stopped", v, 8'h1F);
    wrCtrl(8'h08);
    waitCyc(30);
    peek(2'd0, v); chk("R11 code 8 idle", v, 8'h08);

    // R4 and R5: interrupt mode
    sampleIn = 10'h200;
    wrCtrl(8'h45);
    waitCyc(16);
    chk("R4 irq early", {7'd0, irqReq}, 8'h00);
    waitCyc(1);
    chk("R4 irq raised", {7'd0, irqReq}, 8'h01);
    peek(2'd0, v); chk("R4 flag masked", v, 8'h45);
    wrCtrl(8'h45);
    chk("R5 write clears", {7'd0, irqReq}, 8'h00);
    waitCyc(17);
    chk("R4 irq again", {7'd0, irqReq}, 8'h01);
    rdReg(2'd1, v); chk("R7 hi irq mode", v, 8'h02);
    chk("R5 read clears", {7'd0, irqReq}, 8'h00);
    rdReg(2'd2, v);

    // R4: enabling interrupts discards a pending flag
    wrCtrl(8'h00);
    waitCyc(17);
    peek(2'd0, v); chk("R3 flag before", v, 8'h80);
    wrCtrl(8'h40);
    waitCyc(17);
    wrCtrl(8'h00);
    peek(2'd0, v); chk("R4 flag discarded", v, 8'h00);
    waitCyc(17);
    rdReg(2'd2, v);

    // R9: continuous conversions with interrupts
    sampleIn = 10'h155;
    wrCtrl(8'h62);
    waitCyc(17);
    chk("R9 first irq", {7'd0, irqReq}, 8'h01);
    rdReg(2'd2, v); chk("R9 first lo", v, 8'h55);
    sampleIn = 10'h0AA;
    waitCyc(15);
    chk("R9 gap", {7'd0, irqReq}, 8'h00);
    waitCyc(1);
    chk("R9 second irq", {7'd0, irqReq}, 8'h01);
    rdReg(2'd1, v); chk("R9 second hi", v, 8'h00);
    rdReg(2'd2, v); chk("R9 second lo", v, 8'hAA);

    // R9: one-shot runs once
    wrCtrl(8'h02);
    waitCyc(17);
    peek(2'd0, v); chk("R9 single done", v, 8'h82);
    rdReg(2'd2, v);
    waitCyc(40);
    peek(2'd0, v); chk("R9 single once", v, 8'h02);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule